// File: doc/BRIEF.md
# Chip-Select Extended Bus Sequencer

This block runs one access at a time on an external asynchronous memory bus. It takes each access from an internal request port. A request names a chip-select space, an address, write data, two byte enables and a direction. The sequencer then drives the active-low chip selects, the read strobe, the high and low byte write strobes, the address and the outgoing data with its enable. A plain access takes two strobe clocks. Each space has its own configuration bit. When that bit is set, the access gains a leading setup clock and a trailing hold clock. In those clocks only the chip select is driven, so the strobes always fall strictly inside the chip-select window, and write data stays on the bus through the hold clock.

The request side is valid/ready. `req_ready` is high only while the sequencer is idle. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. While an access is running, `req_ready` is low, and any valid request is left pending in the requester without being taken. The response side has no back-pressure. `rsp_valid` is a one-clock pulse on the last cycle of every access, and read data comes with it, so the requester must take it in that cycle.

Top module: `csx_bus_seq`

## Requirements
- R1: While reset is held and after reset is released, every chip select and strobe is high, `bus_doe` is low, `rsp_valid` is low and `req_ready` is high.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low in every cycle of an access, and a request presented during an access is never started.
- R3: When the extension bit of the target space is clear, the access lasts exactly the two cycles after the accepting edge. Chip select and the strobe are low in both cycles.
- R4: When the extension bit is set, the access lasts four cycles. Chip select is low in all four, and the strobes are low only in the second and third.
- R5: Bit i of `ext_en` selects extension for space i. It is sampled on the accepting edge, so a change during an access has no effect on that access.
- R6: Only `bus_cs_n[req_space]` goes low, where the space index is binary; all other chip selects stay high.
- R7: `bus_addr` equals the accepted address in every cycle of the access.
- R8: For writes, `bus_doe` is high and `bus_dout` holds the accepted data in every cycle of the access, including the hold cycle. For reads, `bus_doe` stays low.
- R9: On writes, `bus_wrh_n` is low in the strobe cycles only if `req_be[1]` was set, and `bus_wrl_n` only if `req_be[0]` was set; `bus_rd_n` stays high. On reads, both write strobes stay high.
- R10: `rsp_valid` pulses for one cycle, in the last cycle of each access. For reads, `rsp_rdata` equals `bus_din` as sampled at the clock edge that ends the second strobe cycle.
- R11: After every access there is at least one cycle with all chip selects high before the next access begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_en | input | NSPACE | Per-space extension enable |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | SPW | Target chip-select space index |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_be | input | 2 | Byte enables {high, low} |
| rsp_valid | output | 1 | Done pulse, last cycle of access |
| rsp_rdata | output | DW | Read data |
| bus_cs_n | output | NSPACE | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wrh_n | output | 1 | Active-low high-byte write strobe |
| bus_wrl_n | output | 1 | Active-low low-byte write strobe |
| bus_addr | output | AW | Address bus |
| bus_dout | output | DW | Outgoing data bus |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | DW | Incoming data bus |

## Verification
The bench compares accesses with and without the extension bit, on reads and writes. A design that puts strobes in the setup or hold clock, or drops the hold clock, shows up as a strobe or chip-select mismatch in a specific cycle. A design that stops driving write data too early shows up as `bus_doe` low in the hold cycle. The bench changes `bus_din` right after the capture edge, which exposes a design that samples read data late or passes the live bus through in the hold cycle. It also flips `ext_en` in the middle of an access and offers a request while the sequencer is busy, which catches a design that re-reads the configuration or takes requests while not idle. Byte-enable patterns and a space change between back-to-back accesses check strobe selection, chip-select decode and the idle gap.

// File: rtl/csx_pkg.sv
package csx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_STRB1 = 3'd2,
    ST_STRB2 = 3'd3,
    ST_HOLD  = 3'd4
  } csx_state_e;
endpackage

// File: rtl/csx_fsm.sv
module csx_fsm
  import csx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ext_sel,
  output csx_state_e state,
  output logic       done
);
  csx_state_e nxt;
  logic       ext_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ext_q <= 1'b0;
    end else begin
      state <= nxt;
      if (start) ext_q <= ext_sel;
    end
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start) nxt = ext_sel ? ST_SETUP : ST_STRB1;
      ST_SETUP: nxt = ST_STRB1;
      ST_STRB1: nxt = ST_STRB2;
      ST_STRB2: nxt = ext_q ? ST_HOLD : ST_IDLE;
      ST_HOLD:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  // last cycle of the access
  assign done = (state == ST_HOLD) || (state == ST_STRB2 && !ext_q);
endmodule

// File: rtl/csx_req_reg.sv
module csx_req_reg #(
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int SPW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           in_write,
  input  logic [SPW-1:0] in_space,
  input  logic [AW-1:0]  in_addr,
  input  logic [DW-1:0]  in_wdata,
  input  logic [1:0]     in_be,
  output logic           wr_q,
  output logic [SPW-1:0] space_q,
  output logic [AW-1:0]  addr_q,
  output logic [DW-1:0]  wdata_q,
  output logic [1:0]     be_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      space_q <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (load) begin
      wr_q    <= in_write;
      space_q <= in_space;
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
      be_q    <= in_be;
    end
  end
endmodule

// File: rtl/csx_pin_drv.sv
module csx_pin_drv
  import csx_pkg::*;
#(
  parameter int NSPACE = 4,
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int SPW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  csx_state_e        state,
  input  logic              wr_q,
  input  logic [SPW-1:0]    space_q,
  input  logic [AW-1:0]     addr_q,
  input  logic [DW-1:0]     wdata_q,
  input  logic [1:0]        be_q,
  input  logic [DW-1:0]     bus_din,
  output logic [NSPACE-1:0] bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wrh_n,
  output logic              bus_wrl_n,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_doe,
  output logic [DW-1:0]     rsp_rdata
);
  logic          busy, strobe;
  logic [DW-1:0] rdata_q;

  assign busy   = (state != ST_IDLE);
  assign strobe = (state == ST_STRB1) || (state == ST_STRB2);

  for (genvar i = 0; i < NSPACE; i++) begin : g_cs
    assign bus_cs_n[i] = !(busy && (space_q == SPW'(i)));
  end

  assign bus_rd_n  = !(strobe && !wr_q);
  assign bus_wrh_n = !(strobe && wr_q && be_q[1]);
  assign bus_wrl_n = !(strobe && wr_q && be_q[0]);
  assign bus_addr  = addr_q;
  assign bus_dout  = wdata_q;
  assign bus_doe   = busy && wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                           rdata_q <= '0;
    else if (state == ST_STRB2 && !wr_q)  rdata_q <= bus_din;
  end

  // in the second strobe cycle the sample is the live bus; afterwards the capture
  assign rsp_rdata = (state == ST_STRB2) ? bus_din : rdata_q;
endmodule

// File: rtl/csx_bus_seq.sv
module csx_bus_seq
  import csx_pkg::*;
#(
  parameter int NSPACE = 4,
  parameter int AW     = 20,
  parameter int DW     = 16,
  localparam int SPW   = (NSPACE > 1) ? $clog2(NSPACE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSPACE-1:0] ext_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [SPW-1:0]    req_space,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [NSPACE-1:0] bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wrh_n,
  output logic              bus_wrl_n,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_doe,
  input  logic [DW-1:0]     bus_din
);
  csx_state_e     state;
  logic           start, ext_sel;
  logic           wr_q;
  logic [SPW-1:0] space_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [1:0]     be_q;

  assign req_ready = (state == ST_IDLE);
  assign start     = req_valid && req_ready;
  assign ext_sel   = ext_en[req_space];

  csx_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_sel(ext_sel),
    .state(state), .done(rsp_valid)
  );

  csx_req_reg #(.AW(AW), .DW(DW), .SPW(SPW)) u_req (
    .clk(clk), .rst_n(rst_n), .load(start),
    .in_write(req_write), .in_space(req_space), .in_addr(req_addr),
    .in_wdata(req_wdata), .in_be(req_be),
    .wr_q(wr_q), .space_q(space_q), .addr_q(addr_q),
    .wdata_q(wdata_q), .be_q(be_q)
  );

  csx_pin_drv #(.NSPACE(NSPACE), .AW(AW), .DW(DW), .SPW(SPW)) u_pins (
    .clk(clk), .rst_n(rst_n), .state(state), .wr_q(wr_q),
    .space_q(space_q), .addr_q(addr_q), .wdata_q(wdata_q), .be_q(be_q),
    .bus_din(bus_din), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wrh_n(bus_wrh_n), .bus_wrl_n(bus_wrl_n), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/csx_bus_seq_chk.sv
module csx_bus_seq_chk #(
  parameter int NSPACE = 4,
  parameter int AW     = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [NSPACE-1:0] bus_cs_n,
  input logic              bus_rd_n,
  input logic              bus_wrh_n,
  input logic              bus_wrl_n,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_doe
);
  logic any_cs;
  assign any_cs = !(&bus_cs_n);

  p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wrh_n || !bus_wrl_n) |-> any_cs);

  p_cs_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !any_cs);

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_cs |-> !req_ready);

  p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (any_cs && $past(any_cs)) |-> $stable(bus_addr));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_idle_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !any_cs);

  p_no_read_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> bus_rd_n);

  p_doe_in_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> any_cs);
endmodule

bind csx_bus_seq csx_bus_seq_chk #(.NSPACE(NSPACE), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wrh_n(bus_wrh_n),
  .bus_wrl_n(bus_wrl_n), .bus_addr(bus_addr), .bus_doe(bus_doe)
);

// File: tb/tb_csx_bus_seq.sv
`timescale 1ns/1ps
module tb_csx_bus_seq;
  localparam int NSPACE = 4;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int NC = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [NSPACE-1:0] ext_en;
  logic req_valid, req_ready, req_write;
  logic [1:0] req_space;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [1:0] req_be;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [NSPACE-1:0] bus_cs_n;
  logic bus_rd_n, bus_wrh_n, bus_wrl_n, bus_doe;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout, bus_din;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  csx_bus_seq #(.NSPACE(NSPACE), .AW(AW), .DW(DW)) dut (.*);

  // per-cycle observations, index 1..NC after the accepting edge
  logic [NSPACE-1:0] o_cs  [NC+1];
  logic              o_rd  [NC+1];
  logic              o_wh  [NC+1];
  logic              o_wl  [NC+1];
  logic              o_oe  [NC+1];
  logic              o_rv  [NC+1];
  logic              o_rdy [NC+1];
  logic [AW-1:0]     o_ad  [NC+1];
  logic [DW-1:0]     o_do  [NC+1];
  logic [DW-1:0]     o_rdd [NC+1];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // issue one access and record NC cycles; optional mid-access actions
  task automatic run(input bit wr, input int sp, input logic [AW-1:0] a,
                     input logic [DW-1:0] wd, input logic [1:0] be,
                     input logic [DW-1:0] din, input int t2,
                     input bit flip_ext, input bit poke);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_space = 2'(sp);
    req_addr = a; req_wdata = wd; req_be = be; bus_din = din;
    @(posedge clk);
    for (int k = 1; k <= NC; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        if (flip_ext) ext_en = ~ext_en;
      end
      o_cs[k] = bus_cs_n; o_rd[k] = bus_rd_n; o_wh[k] = bus_wrh_n;
      o_wl[k] = bus_wrl_n; o_oe[k] = bus_doe; o_rv[k] = rsp_valid;
      o_rdy[k] = req_ready; o_ad[k] = bus_addr; o_do[k] = bus_dout;
      o_rdd[k] = rsp_rdata;
      if (poke && k == 1) begin
        req_valid = 1'b1; req_addr = ~a; req_space = 2'(sp + 1);
      end
      if (poke && k == 2) req_valid = 1'b0;
      if (k == t2) begin
        @(posedge clk);
        #1 bus_din = ~din;
      end
    end
  endtask

  // check the recorded access against the expected shape
  task automatic expect_access(input bit wr, input int sp, input bit ext,
                               input logic [AW-1:0] a, input logic [DW-1:0] wd,
                               input logic [1:0] be, input logic [DW-1:0] din);
    int len = ext ? 4 : 2;
    for (int k = 1; k <= NC; k++) begin
      bit in_acc = (k <= len);
      bit strb = ext ? (k == 2 || k == 3) : (k <= 2);
      logic [NSPACE-1:0] ecs = in_acc ? ~(NSPACE'(1) << sp) : '1;
      chk(o_cs[k] == ecs, ext ? "R4 R6 cs" : "R3 R6 cs", 32'(o_cs[k]), 32'(ecs));
      chk(o_rd[k] == !(strb && !wr), ext ? "R4 rd" : "R3 rd", 32'(o_rd[k]), 32'(!(strb && !wr)));
      chk(o_wh[k] == !(strb && wr && be[1]), "R9 wrh", 32'(o_wh[k]), 32'(!(strb && wr && be[1])));
      chk(o_wl[k] == !(strb && wr && be[0]), "R9 wrl", 32'(o_wl[k]), 32'(!(strb && wr && be[0])));
      chk(o_oe[k] == (in_acc && wr), "R8 doe", 32'(o_oe[k]), 32'(in_acc && wr));
      chk(o_rv[k] == (k == len), "R10 done", 32'(o_rv[k]), 32'(k == len));
      chk(o_rdy[k] == !in_acc, "R2 ready", 32'(o_rdy[k]), 32'(!in_acc));
      if (in_acc) begin
        chk(o_ad[k] == a, "R7 addr", 32'(o_ad[k]), 32'(a));
        if (wr) chk(o_do[k] == wd, "R8 dout", 32'(o_do[k]), 32'(wd));
      end
      if (k == len + 1) chk(o_cs[k] == '1, "R11 gap", 32'(o_cs[k]), 32'hF);
    end
    if (!wr) chk(o_rdd[len] == din, "R10 rdata", 32'(o_rdd[len]), 32'(din));
  endtask

  task automatic t_reset;
    chk(bus_cs_n == '1, "R1 cs", 32'(bus_cs_n), 32'hF);
    chk(bus_rd_n && bus_wrh_n && bus_wrl_n, "R1 strobes", 32'({bus_rd_n, bus_wrh_n, bus_wrl_n}), 32'h7);
    chk(!bus_doe && !rsp_valid, "R1 doe/done", 32'({bus_doe, rsp_valid}), 32'h0);
    chk(req_ready, "R1 ready", 32'(req_ready), 32'h1);
  endtask

  task automatic t_plain_read;
    ext_en = 4'b0000;
    run(1'b0, 1, 20'h1_2345, 16'h0, 2'b11, 16'hBEEF, 2, 1'b0, 1'b0);
    expect_access(1'b0, 1, 1'b0, 20'h1_2345, 16'h0, 2'b11, 16'hBEEF);
  endtask

  task automatic t_ext_read;
    ext_en = 4'b0100; // R5: bit 2 -> space 2
    run(1'b0, 2, 20'hA_0F0F, 16'h0, 2'b11, 16'h5A3C, 3, 1'b0, 1'b0);
    expect_access(1'b0, 2, 1'b1, 20'hA_0F0F, 16'h0, 2'b11, 16'h5A3C);
  endtask

  task automatic t_ext_write_word;
    ext_en = 4'b1000;
    run(1'b1, 3, 20'hF_FFFE, 16'hC0DE, 2'b11, 16'h0, 0, 1'b0, 1'b0);
    expect_access(1'b1, 3, 1'b1, 20'hF_FFFE, 16'hC0DE, 2'b11, 16'h0);
  endtask

  task automatic t_byte_writes;
    ext_en = 4'b0000;
    run(1'b1, 0, 20'h0_0010, 16'h00AA, 2'b01, 16'h0, 0, 1'b0, 1'b0);
    expect_access(1'b1, 0, 1'b0, 20'h0_0010, 16'h00AA, 2'b01, 16'h0);
    run(1'b1, 0, 20'h0_0011, 16'hBB00, 2'b10, 16'h0, 0, 1'b0, 1'b0);
    expect_access(1'b1, 0, 1'b0, 20'h0_0011, 16'hBB00, 2'b10, 16'h0);
  endtask

  task automatic t_ext_other_space; // R5: ext for space 1 does not extend space 0
    ext_en = 4'b0010;
    run(1'b0, 0, 20'h3_3333, 16'h0, 2'b11, 16'h1111, 2, 1'b0, 1'b0);
    expect_access(1'b0, 0, 1'b0, 20'h3_3333, 16'h0, 2'b11, 16'h1111);
  endtask

  task automatic t_ext_flip; // R5: change mid-access ignored
    ext_en = 4'b0001;
    run(1'b1, 0, 20'h5_5555, 16'h7E7E, 2'b11, 16'h0, 0, 1'b1, 1'b0);
    expect_access(1'b1, 0, 1'b1, 20'h5_5555, 16'h7E7E, 2'b11, 16'h0);
    ext_en = 4'b0000;
    run(1'b1, 0, 20'h5_5556, 16'h8181, 2'b11, 16'h0, 0, 1'b1, 1'b0);
    expect_access(1'b1, 0, 1'b0, 20'h5_5556, 16'h8181, 2'b11, 16'h0);
  endtask

  task automatic t_busy_request; // R2: request during access not taken
    ext_en = 4'b0010;
    run(1'b0, 1, 20'h2_4680, 16'h0, 2'b11, 16'h9999, 3, 1'b0, 1'b1);
    expect_access(1'b0, 1, 1'b1, 20'h2_4680, 16'h0, 2'b11, 16'h9999);
    chk(bus_cs_n == '1, "R2 no late start", 32'(bus_cs_n), 32'hF);
  endtask

  initial begin : watchdog
    #200000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_en = '0; req_valid = 1'b0; req_write = 1'b0;
    req_space = '0; req_addr = '0; req_wdata = '0; req_be = '0; bus_din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_read();
    t_ext_read();
    t_ext_write_word();
    t_byte_writes();
    t_ext_other_space();
    t_ext_flip();
    t_busy_request();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule